// File: doc/BRIEF.md
# Timer Overflow Toggle Latch

This block turns the single-cycle overflow or underflow pulse of a core timer into a level that flips on every such event. It keeps that level in a toggle flip-flop and keeps a shadow flip-flop that copies it one clock later. The two flip-flops differ for exactly one clock after a hardware toggle. That difference is decoded into a trigger pulse that auxiliary timers can use as a count event or as a reload event. An edge-select input picks which direction of change raises the trigger.

Software can force the toggle bit to a chosen value. Such a write loads the shadow at the same time, so software changes never produce a trigger. A pin output shows the toggle level when enabled and sits high otherwise. Both flip-flop levels are brought out for the auxiliary timer input logic, and the toggle level also serves as the readable status bit.

Top module: `ovf_toggle_unit`

## Requirements
- R1: A high `ovf_pulse` at a clock edge with `sw_wr` low inverts `tgl_lvl`. With both low, `tgl_lvl` holds its value.
- R2: When `sw_wr` was low at the previous edge, `shd_lvl` equals the value `tgl_lvl` had before that edge.
- R3: `trig` is high exactly when the selected condition holds. `edge_sel` = 2'b01 selects rising (`tgl_lvl`=1, `shd_lvl`=0). 2'b10 selects falling (`tgl_lvl`=0, `shd_lvl`=1). 2'b11 selects either of these. 2'b00 keeps `trig` low.
- R4: A high `sw_wr` at a clock edge loads `sw_data` into both `tgl_lvl` and `shd_lvl`, and `trig` is low in the following cycle.
- R5: `pin_out` equals `tgl_lvl` while `out_en` is 1 and is 1 while `out_en` is 0.
- R6: The toggle level and the shadow level are both visible at all times on `tgl_lvl` and `shd_lvl`. `tgl_lvl` is the readable status of the toggle bit.
- R7: When `sw_wr` and `ovf_pulse` are both high at the same edge, the write wins: both flip-flops take `sw_data` and no trigger follows.
- R8: While `rst_n` is low, both flip-flops are 0. In the first cycle after reset, `trig` is low.
- R9: Overflow pulses on consecutive cycles each toggle the level, and the trigger alternates between rising and falling each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovf_pulse | input | 1 | Core timer overflow/underflow pulse |
| sw_wr | input | 1 | Software write strobe for the toggle bit |
| sw_data | input | 1 | Value written by software |
| out_en | input | 1 | Pin output enable |
| edge_sel | input | 2 | Trigger direction select |
| tgl_lvl | output | 1 | Toggle flip-flop level (status) |
| shd_lvl | output | 1 | Shadow flip-flop level |
| trig | output | 1 | Trigger pulse for auxiliary timers |
| pin_out | output | 1 | Pin output level |

## Verification
The clocked assertions assume that `ovf_pulse` and `sw_wr` are low while reset is asserted. The toggle and write properties start their check in the cycle the reset releases, and a pulse seen during reset would look like a lost toggle. The bench holds both strobes low for the whole reset phase. After that it drives every input freely, including simultaneous writes and overflows and back-to-back pulses.

// File: rtl/ovf_toggle_unit.sv
module ovf_toggle_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_pulse,
  input  logic       sw_wr,
  input  logic       sw_data,
  input  logic       out_en,
  input  logic [1:0] edge_sel,
  output logic       tgl_lvl,
  output logic       shd_lvl,
  output logic       trig,
  output logic       pin_out
);

  logic tgl_q, shd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_q <= 1'b0;
      shd_q <= 1'b0;
    end else if (sw_wr) begin
      tgl_q <= sw_data;
      shd_q <= sw_data;
    end else begin
      tgl_q <= tgl_q ^ ovf_pulse;
      shd_q <= tgl_q;
    end
  end

  assign tgl_lvl = tgl_q;
  assign shd_lvl = shd_q;
  assign trig    = (edge_sel[0] & tgl_q & ~shd_q) | (edge_sel[1] & ~tgl_q & shd_q);
  assign pin_out = out_en ? tgl_q : 1'b1;

  AST_OVF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && !sw_wr) |=> (tgl_lvl != $past(tgl_lvl))); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_pulse && !sw_wr) |=> $stable(tgl_lvl)); // R1
  AST_SHADOW_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> (shd_lvl == $past(tgl_lvl))); // R2
  AST_SEL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'b00) |-> !trig); // R3
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (tgl_lvl == $past(sw_data)) && (shd_lvl == $past(sw_data)) && !trig); // R4
  AST_PIN_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> pin_out); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !trig); // R8

endmodule

// File: tb/ovf_toggle_unit_tb.sv
module ovf_toggle_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovf_pulse = 1'b0, sw_wr = 1'b0, sw_data = 1'b0, out_en = 1'b0;
  logic [1:0] edge_sel = 2'b00;
  logic tgl_lvl, shd_lvl, trig, pin_out;

  int checks = 0, errors = 0;
  int m_tgl = 0, m_shd = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ovf_toggle_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse), .sw_wr(sw_wr),
    .sw_data(sw_data), .out_en(out_en), .edge_sel(edge_sel),
    .tgl_lvl(tgl_lvl), .shd_lvl(shd_lvl), .trig(trig), .pin_out(pin_out)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_trig();
    int rise = (m_tgl == 1 && m_shd == 0);
    int fall = (m_tgl == 0 && m_shd == 1);
    return (edge_sel[0] && rise) || (edge_sel[1] && fall);
  endfunction

  task automatic compare_all();
    chk("R1/R6 tgl_lvl", tgl_lvl, m_tgl);
    chk("R2/R6 shd_lvl", shd_lvl, m_shd);
    chk("R3 trig", trig, exp_trig());
    chk("R5 pin_out", pin_out, out_en ? m_tgl : 1);
  endtask

  task automatic step(bit o, bit w, bit d, bit oe, logic [1:0] sel);
    ovf_pulse = o; sw_wr = w; sw_data = d; out_en = oe; edge_sel = sel;
    @(posedge clk);
    if (w) begin m_tgl = d; m_shd = d; end
    else begin m_shd = m_tgl; if (o) m_tgl = 1 - m_tgl; end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset tgl", tgl_lvl, 0);
    chk("R8 reset shd", shd_lvl, 0);
    chk("R5 pin high when disabled", pin_out, 1);
    rst_n = 1'b1;
    step(0, 0, 0, 1, 2'b11);
    chk("R8 no trigger after reset", trig, 0);

    step(1, 0, 0, 1, 2'b01);
    chk("R1 toggled high", tgl_lvl, 1);
    chk("R3 rising pulse", trig, 1);
    step(0, 0, 0, 1, 2'b01);
    chk("R2 shadow caught up", shd_lvl, 1);
    chk("R3 pulse lasts one cycle", trig, 0);

    step(1, 0, 0, 1, 2'b10);
    chk("R3 falling pulse", trig, 1);
    step(0, 0, 0, 0, 2'b10);
    chk("R5 pin high with enable off", pin_out, 1);

    step(0, 1, 1, 1, 2'b11);
    chk("R4 write sets toggle", tgl_lvl, 1);
    chk("R4 write sets shadow", shd_lvl, 1);
    chk("R4 write gives no trigger", trig, 0);
    step(0, 1, 0, 1, 2'b11);
    chk("R4 write clears, no trigger", trig, 0);

    step(1, 1, 0, 1, 2'b11);
    chk("R7 write beats overflow", tgl_lvl, 0);
    chk("R7 no trigger", trig, 0);

    step(1, 0, 0, 1, 2'b01);
    chk("R9 first pulse rising", trig, 1);
    step(1, 0, 0, 1, 2'b01);
    chk("R9 second pulse not rising", trig, 0);
    step(1, 0, 0, 1, 2'b10);
    chk("R9 third pulse not falling", trig, 0);
    step(1, 0, 0, 1, 2'b10);
    chk("R9 fourth pulse falling", trig, 1);
    step(0, 0, 0, 1, 2'b00);
    chk("R3 select off", trig, 0);

    for (int i = 0; i < 400; i++)
      step($urandom % 2, ($urandom % 5) == 0, $urandom % 2, $urandom % 2, 2'($urandom % 4));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule